// File: doc/BRIEF.md
# Descriptor Table Register Load Unit

This block carries out the two instructions that load a processor's descriptor table base registers: one writes the global table register and the other writes the interrupt table register. The instruction is recognised from its two opcode bytes and the reg field of the ModRM byte. The bus has already fetched the 48-bit memory operand. The block splits that operand into a 16-bit limit and a base address. The base is 32 bits wide or 24 bits wide, depending on the operand size.

Before it writes anything, the block checks the conditions that make the load illegal. These are a register-form operand, a privilege level other than zero in protected mode, a null data-segment selector in protected mode, a 6-byte operand that does not fit inside the segment limit, and a page fault on the fetch. The faults have a fixed priority, and the block reports only the first one that applies. One clock after the request, it emits a single completion pulse together with a one-hot fault vector and an error code. The table registers change on that same edge, and only when no fault is reported.

Top module: `desc_tbl_loader`

## Requirements
- R1: A request is accepted only when the opcode bytes are 0x0F then 0x01 and ModRM bits 5:3 equal 2 or 3. A value of 2 selects the global table register and 3 selects the interrupt table register. Any other request gives no completion pulse and changes neither register.
- R2: The limit is always loaded from operand bits 15:0. When `op32_i` is 1, the full base is loaded from operand bits 47:16.
- R3: When `op32_i` is 0, the base is loaded from operand bits 39:16 and base bits 31:24 are stored as zero. Operand bits 47:40 have no effect.
- R4: A ModRM mod field (bits 7:6) of 3 means a register operand. It raises the invalid-opcode fault in every mode, ahead of all other faults, and neither register changes.
- R5: In protected mode (`mode_i` = 1), a privilege level other than 0 raises a general-protection fault with error code 0. In real mode (`mode_i` = 0) and virtual-8086 mode (`mode_i` = 2), the privilege level is not checked.
- R6: In protected mode, a null selector on the segment used raises a general-protection fault with error code 0. This applies only when the segment code `seg_i` is 0 (ES), 3 (DS), 4 (FS) or 5 (GS); code 1 is CS and code 2 is SS. A null selector has no effect in the other modes.
- R7: A segment-limit violation applies in every mode. It occurs when the sum `ea_i` + 5 exceeds `seg_lim_i`, or when that sum carries past 32 bits. For SS it raises a stack fault, and for every other segment it raises a general-protection fault; both carry error code 0.
- R8: A page-fault indication raises a page fault whose error code is `pf_code_i`. It has the lowest priority, below the privilege, null-selector and limit faults.
- R9: The fault vector is one-hot: bit 0 is invalid opcode, bit 1 general protection, bit 2 stack fault and bit 3 page fault. `done_o` pulses for exactly one cycle, on the edge after an accepted request. The fault vector and error code are valid with `done_o` and are zero otherwise.
- R10: During and after reset, both limits, both bases, `done_o`, `fault_o` and `err_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, one cycle |
| opc0_i | input | 8 | First opcode byte |
| opc1_i | input | 8 | Second opcode byte |
| modrm_i | input | 8 | ModRM byte |
| op32_i | input | 1 | 1 = 32-bit operand size |
| mode_i | input | 2 | 0 real, 1 protected, 2 virtual-8086 |
| cpl_i | input | 2 | Current privilege level |
| seg_i | input | 3 | Segment used: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| seg_null_i | input | 1 | Selector of that segment is null |
| seg_lim_i | input | 32 | Limit of that segment |
| ea_i | input | 32 | Effective address of the operand |
| opnd_i | input | 48 | Fetched 6-byte operand |
| pf_i | input | 1 | Page fault reported on the operand fetch |
| pf_code_i | input | 32 | Page fault error code |
| gt_limit_o | output | 16 | Global table limit |
| gt_base_o | output | 32 | Global table base |
| it_limit_o | output | 16 | Interrupt table limit |
| it_base_o | output | 32 | Interrupt table base |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 4 | One-hot fault vector |
| err_o | output | 32 | Fault error code |

## Verification
The hardest cases to reach are those where several fault conditions are present at once. For example, a page fault can arrive together with a limit violation, or a register operand can arrive together with a bad privilege level. In these cases only the fault with the highest priority may appear.

The vector table sets such combinations deliberately, so each one checks that the lower fault is masked. Further vectors place the operand's last byte exactly on the segment limit and one byte past it. One vector uses an address whose 6-byte span wraps past 32 bits, so the carry path of the limit compare is exercised.

// File: rtl/dtl_pkg.sv
package dtl_pkg;
    localparam int LIM_W   = 16;
    localparam int BASE_W  = 32;
    localparam int NARROW_W = 24;
    localparam int OPND_W  = LIM_W + BASE_W;
    localparam int ADDR_W  = 32;
    localparam int FLT_W   = 4;

    localparam int FLT_UD = 0;
    localparam int FLT_GP = 1;
    localparam int FLT_SS = 2;
    localparam int FLT_PF = 3;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_PROT = 2'd1,
        MODE_V86  = 2'd2
    } cpu_mode_e;

    typedef enum logic [2:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_e;

    typedef struct packed {
        logic [LIM_W-1:0]  limit;
        logic [BASE_W-1:0] base;
    } tbl_reg_t;
endpackage

// File: rtl/dtl_operand_split.sv
module dtl_operand_split #(
    parameter int LIM_W    = 16,
    parameter int BASE_W   = 32,
    parameter int NARROW_W = 24
) (
    input  logic [LIM_W+BASE_W-1:0] opnd_i,
    input  logic                    wide_i,
    output logic [LIM_W-1:0]        limit_o,
    output logic [BASE_W-1:0]       base_o
);
    localparam int PAD_W = BASE_W - NARROW_W;

    always_comb begin
        limit_o = opnd_i[LIM_W-1:0];
        if (wide_i)
            base_o = opnd_i[LIM_W +: BASE_W];
        else
            base_o = {{PAD_W{1'b0}}, opnd_i[LIM_W +: NARROW_W]};
    end
endmodule

// File: rtl/dtl_fault_eval.sv
module dtl_fault_eval
    import dtl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SPAN   = 6
) (
    input  logic              reg_form_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        cpl_i,
    input  logic [2:0]        seg_i,
    input  logic              seg_null_i,
    input  logic [ADDR_W-1:0] seg_lim_i,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic              pf_i,
    input  logic [31:0]       pf_code_i,
    output logic [FLT_W-1:0]  fault_o,
    output logic [31:0]       err_o
);
    localparam logic [ADDR_W:0] LAST_OFS = (ADDR_W+1)'(SPAN - 1);

    logic [ADDR_W:0] span_end;
    logic            prot, data_seg, over;

    always_comb begin
        span_end = {1'b0, ea_i} + LAST_OFS;
        over     = span_end > {1'b0, seg_lim_i};
        prot     = (mode_i == MODE_PROT);
        data_seg = (seg_i == SEG_ES) || (seg_i == SEG_DS) ||
                   (seg_i == SEG_FS) || (seg_i == SEG_GS);
        fault_o  = '0;
        err_o    = '0;
        if (reg_form_i)
            fault_o[FLT_UD] = 1'b1;
        else if (prot && cpl_i != 2'd0)
            fault_o[FLT_GP] = 1'b1;
        else if (prot && data_seg && seg_null_i)
            fault_o[FLT_GP] = 1'b1;
        else if (over) begin
            if (seg_i == SEG_SS) fault_o[FLT_SS] = 1'b1;
            else                 fault_o[FLT_GP] = 1'b1;
        end else if (pf_i) begin
            fault_o[FLT_PF] = 1'b1;
            err_o           = pf_code_i;
        end
    end
endmodule

// File: rtl/desc_tbl_loader.sv
module desc_tbl_loader
    import dtl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [7:0]        opc0_i,
    input  logic [7:0]        opc1_i,
    input  logic [7:0]        modrm_i,
    input  logic              op32_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        cpl_i,
    input  logic [2:0]        seg_i,
    input  logic              seg_null_i,
    input  logic [31:0]       seg_lim_i,
    input  logic [31:0]       ea_i,
    input  logic [47:0]       opnd_i,
    input  logic              pf_i,
    input  logic [31:0]       pf_code_i,
    output logic [15:0]       gt_limit_o,
    output logic [31:0]       gt_base_o,
    output logic [15:0]       it_limit_o,
    output logic [31:0]       it_base_o,
    output logic              done_o,
    output logic [3:0]        fault_o,
    output logic [31:0]       err_o
);
    localparam int NTBL = 2;

    typedef struct packed {
        tbl_reg_t [NTBL-1:0] tbl;
        logic                done;
        logic [FLT_W-1:0]    fault;
        logic [31:0]         err;
    } state_t;

    state_t st_d, st_q;

    logic [LIM_W-1:0]  new_lim;
    logic [BASE_W-1:0] new_base;
    logic [FLT_W-1:0]  flt;
    logic [31:0]       flt_err;
    logic              hit, reg_form, sel;

    dtl_operand_split #(.LIM_W(LIM_W), .BASE_W(BASE_W), .NARROW_W(NARROW_W)) u_split (
        .opnd_i (opnd_i),
        .wide_i (op32_i),
        .limit_o(new_lim),
        .base_o (new_base)
    );

    dtl_fault_eval #(.ADDR_W(ADDR_W), .SPAN(OPND_W/8)) u_fault (
        .reg_form_i(reg_form),
        .mode_i    (mode_i),
        .cpl_i     (cpl_i),
        .seg_i     (seg_i),
        .seg_null_i(seg_null_i),
        .seg_lim_i (seg_lim_i),
        .ea_i      (ea_i),
        .pf_i      (pf_i),
        .pf_code_i (pf_code_i),
        .fault_o   (flt),
        .err_o     (flt_err)
    );

    always_comb begin
        hit      = (opc0_i == 8'h0F) && (opc1_i == 8'h01) && (modrm_i[5:4] == 2'b01);
        reg_form = (modrm_i[7:6] == 2'b11);
        sel      = modrm_i[3];
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.fault = '0;
        st_d.err   = '0;
        if (req_i && hit) begin
            st_d.done  = 1'b1;
            st_d.fault = flt;
            st_d.err   = flt_err;
            if (flt == '0) begin
                st_d.tbl[sel].limit = new_lim;
                st_d.tbl[sel].base  = new_base;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gt_limit_o = st_q.tbl[0].limit;
    assign gt_base_o  = st_q.tbl[0].base;
    assign it_limit_o = st_q.tbl[1].limit;
    assign it_base_o  = st_q.tbl[1].base;
    assign done_o     = st_q.done;
    assign fault_o    = st_q.fault;
    assign err_o      = st_q.err;

    // R9
    fault_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_o) && (fault_o != '0 -> done_o));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o || $past(req_i));

    // R4
    faulted_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o || fault_o != '0) |-> ($stable(gt_base_o) && $stable(gt_limit_o) &&
                                        $stable(it_base_o) && $stable(it_limit_o)));

    // R3
    narrow_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o == '0 && !$past(op32_i) && !$past(modrm_i[3]))
            |-> gt_base_o[31:24] == 8'h00);

    // R8
    pf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o[FLT_PF] |-> err_o == $past(pf_code_i));

    // R5
    priv_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(mode_i) == MODE_PROT && $past(cpl_i) != 2'd0 &&
         $past(modrm_i[7:6]) != 2'b11) |-> (fault_o[FLT_GP] && err_o == '0));
endmodule

// File: tb/desc_tbl_loader_test.sv
module desc_tbl_loader_test;
    typedef struct packed {
        logic        op32;
        logic [1:0]  mode;
        logic [1:0]  cpl;
        logic [7:0]  modrm;
        logic [2:0]  seg;
        logic        snull;
        logic [31:0] lim;
        logic [31:0] ea;
        logic [47:0] opnd;
        logic        pf;
        logic [31:0] pfc;
        logic [3:0]  xf;
        logic [31:0] xe;
    } vec_t;

    localparam int NV = 15;
    // modrm 0x16: memory form reg 2 (global); 0x1E: memory form reg 3 (interrupt); 0xD0: register form reg 2
    localparam vec_t VEC [NV] = '{
        '{1'b1,2'd1,2'd0,8'h16,3'd3,1'b0,32'h0000FFFF,32'h100,48'hA1B2C3D4_0FFF,1'b0,32'h0,4'h0,32'h0}, // R2
        '{1'b0,2'd1,2'd0,8'h1E,3'd3,1'b0,32'h0000FFFF,32'h100,48'h99123456_03FF,1'b0,32'h0,4'h0,32'h0}, // R3
        '{1'b0,2'd0,2'd3,8'h16,3'd3,1'b0,32'h0000FFFF,32'h200,48'h77ABCDEF_0020,1'b0,32'h0,4'h0,32'h0}, // R5 real
        '{1'b1,2'd1,2'd3,8'h16,3'd3,1'b0,32'h0000FFFF,32'h100,48'h11111111_1111,1'b0,32'h0,4'h2,32'h0}, // R5
        '{1'b1,2'd1,2'd0,8'h16,3'd3,1'b1,32'h0000FFFF,32'h100,48'h22222222_2222,1'b0,32'h0,4'h2,32'h0}, // R6
        '{1'b1,2'd0,2'd0,8'h1E,3'd3,1'b1,32'h0000FFFF,32'h100,48'h01020304_0506,1'b0,32'h0,4'h0,32'h0}, // R6 real
        '{1'b1,2'd1,2'd0,8'h16,3'd1,1'b0,32'h00001000,32'h0FFB,48'hDEADBEEF_1234,1'b0,32'h0,4'h0,32'h0}, // R7 edge ok
        '{1'b1,2'd1,2'd0,8'h16,3'd1,1'b0,32'h00001000,32'h0FFC,48'h33333333_3333,1'b0,32'h0,4'h2,32'h0}, // R7
        '{1'b1,2'd1,2'd0,8'h16,3'd2,1'b0,32'h00001000,32'h0FFC,48'h44444444_4444,1'b0,32'h0,4'h4,32'h0}, // R7 SS
        '{1'b1,2'd2,2'd3,8'h16,3'd1,1'b0,32'h00000010,32'h0020,48'h55555555_5555,1'b0,32'h0,4'h2,32'h0}, // R7 v86
        '{1'b1,2'd1,2'd0,8'h1E,3'd3,1'b0,32'h0000FFFF,32'h100,48'h66666666_6666,1'b1,32'h6,4'h8,32'h6}, // R8
        '{1'b1,2'd1,2'd3,8'hD0,3'd3,1'b1,32'h00000000,32'h100,48'h77777777_7777,1'b1,32'h9,4'h1,32'h0}, // R4
        '{1'b1,2'd2,2'd3,8'h1E,3'd0,1'b1,32'h0000FFFF,32'h100,48'hCAFEF00D_7777,1'b0,32'h0,4'h0,32'h0}, // R5 v86
        '{1'b1,2'd1,2'd0,8'h16,3'd3,1'b0,32'hFFFFFFFF,32'hFFFFFFFD,48'h88888888_8888,1'b0,32'h0,4'h2,32'h0}, // R7 wrap
        '{1'b1,2'd1,2'd0,8'h16,3'd4,1'b0,32'h00000010,32'h0020,48'h99999999_9999,1'b1,32'h5,4'h2,32'h0} // R8 masked
    };

    logic        clk = 0, rst_n = 0, req = 0, op32 = 0, snull = 0, pf = 0;
    logic [7:0]  opc0 = 0, opc1 = 0, modrm = 0;
    logic [1:0]  mode = 0, cpl = 0;
    logic [2:0]  seg = 0;
    logic [31:0] lim = 0, ea = 0, pfc = 0;
    logic [47:0] opnd = 0;
    logic [15:0] gt_lim, it_lim;
    logic [31:0] gt_base, it_base, err;
    logic        done;
    logic [3:0]  fault;

    int nchk = 0, nerr = 0;
    logic [15:0] x_lim [2];
    logic [31:0] x_base [2];

    always #2 clk = ~clk;

    desc_tbl_loader uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .opc0_i(opc0), .opc1_i(opc1),
        .modrm_i(modrm), .op32_i(op32), .mode_i(mode), .cpl_i(cpl), .seg_i(seg),
        .seg_null_i(snull), .seg_lim_i(lim), .ea_i(ea), .opnd_i(opnd), .pf_i(pf),
        .pf_code_i(pfc), .gt_limit_o(gt_lim), .gt_base_o(gt_base),
        .it_limit_o(it_lim), .it_base_o(it_base), .done_o(done), .fault_o(fault),
        .err_o(err)
    );

    task automatic chk(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        chk({tag, " gt limit"}, 64'(gt_lim), 64'(x_lim[0]));
        chk({tag, " gt base"},  64'(gt_base), 64'(x_base[0]));
        chk({tag, " it limit"}, 64'(it_lim), 64'(x_lim[1]));
        chk({tag, " it base"},  64'(it_base), 64'(x_base[1]));
    endtask

    initial begin
        #(4 * 200000);
        nerr++;
        nchk++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin x_lim[k] = '0; x_base[k] = '0; end
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 done", 64'(done), 64'd0);
        chk("R10 fault", 64'(fault), 64'd0);
        chk_regs("R10");
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            opc0 = 8'h0F; opc1 = 8'h01;
            op32 = VEC[i].op32; mode = VEC[i].mode; cpl = VEC[i].cpl;
            modrm = VEC[i].modrm; seg = VEC[i].seg; snull = VEC[i].snull;
            lim = VEC[i].lim; ea = VEC[i].ea; opnd = VEC[i].opnd;
            pf = VEC[i].pf; pfc = VEC[i].pfc;
            req = 1;
            @(negedge clk);
            req = 0;
            if (VEC[i].xf == 4'h0) begin
                x_lim[VEC[i].modrm[3]]  = VEC[i].opnd[15:0];
                x_base[VEC[i].modrm[3]] = VEC[i].op32 ? VEC[i].opnd[47:16]
                                                      : {8'h00, VEC[i].opnd[39:16]};
            end
            // R1 R9: one pulse, fault vector and code
            chk($sformatf("R9 done vec%0d", i), 64'(done), 64'd1);
            chk($sformatf("R9 fault vec%0d", i), 64'(fault), 64'(VEC[i].xf));
            chk($sformatf("R9 err vec%0d", i), 64'(err), 64'(VEC[i].xe));
            chk_regs($sformatf("R2 R3 R4 vec%0d", i));
            @(negedge clk);
            chk($sformatf("R9 pulse end vec%0d", i), 64'(done), 64'd0);
            chk($sformatf("R9 fault clear vec%0d", i), 64'(fault), 64'd0);
        end

        // R1: wrong second opcode byte ignored
        opc0 = 8'h0F; opc1 = 8'h00; modrm = 8'h16; mode = 2'd1; cpl = 0;
        snull = 0; lim = 32'hFFFF; ea = 32'h10; pf = 0; op32 = 1;
        opnd = 48'hFEDCBA98_7654; req = 1;
        @(negedge clk);
        req = 0;
        chk("R1 bad opcode done", 64'(done), 64'd0);
        chk_regs("R1 bad opcode");

        // R1: reg field 1 under correct opcode ignored
        opc1 = 8'h01; modrm = 8'h0E; req = 1;
        @(negedge clk);
        req = 0;
        chk("R1 reg field done", 64'(done), 64'd0);
        chk_regs("R1 reg field");

        // R3: high operand byte does not reach the base in narrow mode
        modrm = 8'h16; op32 = 0; opnd = 48'hFF000000_0001; req = 1;
        @(negedge clk);
        req = 0;
        x_lim[0] = 16'h0001; x_base[0] = 32'h0;
        chk("R3 narrow high byte", 64'(gt_base), 64'h0);
        chk_regs("R3 narrow");

        // R10: reset mid-run clears state
        rst_n = 0;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin x_lim[k] = '0; x_base[k] = '0; end
        chk_regs("R10 rereset");
        rst_n = 1;

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule